// File: doc/BRIEF.md
# MSI Vector Delivery Engine

This block converts interrupt requests from device logic into message-signalled interrupt writes. Device logic offers a vector index on a valid/ready request port. The engine reads the current capability settings: enable, address width mode, the log2 of the enabled vector count, the address words, the data template, whether per-vector masking exists, and the mask bits. From these it either emits one address/data message on a valid/ready output port, or records the vector as pending.

A masked vector is not dropped. Its pending bit is set, and it is replayed later. Each configuration write that lands while the engine is enabled starts a rescan. The rescan first clears pending bits that lie beyond the enabled vector count. It then walks the vectors upward from index 0 and issues a message for every vector that is pending and unmasked. New requests are held off while a rescan is pending or running. A request naming a vector outside the enabled range is discarded and sets a sticky error flag.

Top module: `msi_vec_engine`

## Requirements
- R1: When masking is present (`cfg_mask_cap`=1) and bit v of `cfg_mask` is 1, an accepted request for vector v sets bit v of `pend` and produces no message.
- R2: When `cfg_mask_cap`=0, no vector is treated as masked: every in-range request produces a message, and `pend` reads all zero one cycle later.
- R3: `msg_addr` is {32'h0, `cfg_addr_lo`} when `cfg_addr64`=0, and {`cfg_addr_hi`, `cfg_addr_lo`} when `cfg_addr64`=1.
- R4: `msg_data` bits [31:16] are zero, and bits [15:0] come from `cfg_data`. The enabled count is N = 2^`cfg_log_n`. When N > 1, the low `cfg_log_n` bits are replaced by the vector number. When N = 1, the data template is sent unchanged.
- R5: A request with vector index >= N is discarded with no message and sets `err`. Once set, `err` stays 1 until reset.
- R6: A `cfg_wr` pulse while `cfg_enable`=1 clears every pending bit at index >= N.
- R7: After that trim, the rescan visits vectors in ascending order. Each vector that is pending and unmasked has its pending bit cleared and a message issued. Pending vectors that are still masked keep their bit.
- R8: `req_ready` is 0 from the cycle after an enabled `cfg_wr` until the rescan has finished.
- R9: While `cfg_enable`=0, requests are accepted and discarded with no message, and `cfg_wr` pulses leave `pend` unchanged.
- R10: A message that is offered while `msg_ready`=0 stays valid, and its address and data stay unchanged, until it is taken.
- R11: After reset, `msg_valid`, `err` and `pend` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Message delivery enabled |
| cfg_addr64 | input | 1 | 1 selects 64-bit message addressing |
| cfg_mask_cap | input | 1 | Per-vector masking is present |
| cfg_log_n | input | LOG_W | log2 of the enabled vector count |
| cfg_addr_lo | input | 32 | Low address word |
| cfg_addr_hi | input | 32 | High address word |
| cfg_data | input | 16 | Message data template |
| cfg_mask | input | MAX_VEC | Per-vector mask bits |
| cfg_wr | input | 1 | One-cycle pulse marking a configuration write |
| req_valid | input | 1 | Request offered |
| req_vec | input | VEC_W | Requested vector index |
| req_ready | output | 1 | Request can be accepted |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| pend | output | MAX_VEC | Pending vector bits |
| err | output | 1 | Sticky out-of-range request flag |

## Verification
The bench builds the engine with MAX_VEC=8, so LOG_W is 2 and the enabled count ranges from 1 to 8. With these values every legal vector count can be set, including the single-vector case where the data template is sent unchanged and the full count where nothing is out of range. The small vector space also means random requests often fall beyond a reduced count. Random mask and pending patterns then give rescans that mix trimming, replay and retained bits in a few dozen cycles.

// File: rtl/msi_eng_pkg.sv
package msi_eng_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } eng_state_e;
endpackage

// File: rtl/msi_vec_decode.sv
// Range and mask decode for one vector index against the enabled count.
module msi_vec_decode #(
    parameter int MAX_VEC = 32,
    parameter int VEC_W   = $clog2(MAX_VEC),
    parameter int LOG_W   = $clog2($clog2(MAX_VEC) + 1)
) (
    input  logic [LOG_W-1:0]   log_n,
    input  logic [VEC_W-1:0]   vec,
    input  logic               mask_cap,
    input  logic [MAX_VEC-1:0] mask,
    output logic               in_range,
    output logic               masked,
    output logic               last,
    output logic [MAX_VEC-1:0] live
);
    logic [31:0] n_cnt;
    logic [31:0] vec_ext;

    assign n_cnt    = 32'd1 << log_n;
    assign vec_ext  = {{(32-VEC_W){1'b0}}, vec};
    assign in_range = vec_ext < n_cnt;
    assign last     = vec_ext == (n_cnt - 32'd1);
    assign masked   = mask_cap & mask[vec];

    for (genvar i = 0; i < MAX_VEC; i++) begin : g_live
        assign live[i] = 32'(i) < n_cnt;
    end
endmodule

// File: rtl/msi_msg_fmt.sv
// Builds the message address and data for one vector.
module msi_msg_fmt #(
    parameter int VEC_W = 5,
    parameter int LOG_W = 3
) (
    input  logic             addr64,
    input  logic [31:0]      addr_lo,
    input  logic [31:0]      addr_hi,
    input  logic [15:0]      data_tpl,
    input  logic [LOG_W-1:0] log_n,
    input  logic [VEC_W-1:0] vec,
    output logic [63:0]      addr,
    output logic [31:0]      data
);
    logic [31:0] low_field;

    assign low_field = (32'd1 << log_n) - 32'd1;
    assign addr = addr64 ? {addr_hi, addr_lo} : {32'h0, addr_lo};
    assign data = ({16'h0, data_tpl} & ~low_field) | {{(32-VEC_W){1'b0}}, vec};
endmodule

// File: rtl/msi_vec_engine.sv
module msi_vec_engine #(
    parameter int MAX_VEC = 32,
    parameter int VEC_W   = $clog2(MAX_VEC),
    parameter int LOG_W   = $clog2($clog2(MAX_VEC) + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic               cfg_addr64,
    input  logic               cfg_mask_cap,
    input  logic [LOG_W-1:0]   cfg_log_n,
    input  logic [31:0]        cfg_addr_lo,
    input  logic [31:0]        cfg_addr_hi,
    input  logic [15:0]        cfg_data,
    input  logic [MAX_VEC-1:0] cfg_mask,
    input  logic               cfg_wr,
    input  logic               req_valid,
    input  logic [VEC_W-1:0]   req_vec,
    output logic               req_ready,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic [MAX_VEC-1:0] pend,
    output logic               err
);
    import msi_eng_pkg::*;

    typedef struct packed {
        eng_state_e         st;
        logic [VEC_W-1:0]   idx;
        logic               rescan;
        logic [MAX_VEC-1:0] pend;
        logic               err;
        logic               mv;
        logic [63:0]        maddr;
        logic [31:0]        mdata;
    } eng_t;

    eng_t r_d, r_q;

    logic               acc;
    logic [VEC_W-1:0]   cur_vec;
    logic               cur_in_range;
    logic               cur_masked;
    logic               cur_last;
    logic [MAX_VEC-1:0] live_bits;
    logic [63:0]        fmt_addr;
    logic [31:0]        fmt_data;

    // One decode and one formatter serve both the request path and the scan.
    assign cur_vec = (r_q.st == ST_SCAN) ? r_q.idx : req_vec;

    msi_vec_decode #(.MAX_VEC(MAX_VEC), .VEC_W(VEC_W), .LOG_W(LOG_W)) u_dec (
        .log_n    (cfg_log_n),
        .vec      (cur_vec),
        .mask_cap (cfg_mask_cap),
        .mask     (cfg_mask),
        .in_range (cur_in_range),
        .masked   (cur_masked),
        .last     (cur_last),
        .live     (live_bits)
    );

    msi_msg_fmt #(.VEC_W(VEC_W), .LOG_W(LOG_W)) u_fmt (
        .addr64   (cfg_addr64),
        .addr_lo  (cfg_addr_lo),
        .addr_hi  (cfg_addr_hi),
        .data_tpl (cfg_data),
        .log_n    (cfg_log_n),
        .vec      (cur_vec),
        .addr     (fmt_addr),
        .data     (fmt_data)
    );

    assign req_ready = (r_q.st == ST_IDLE) && !r_q.rescan && !r_q.mv;
    assign acc       = req_valid && req_ready;

    always_comb begin
        r_d = r_q;
        if (r_q.mv && msg_ready) begin
            r_d.mv = 1'b0;
        end
        if (!cfg_enable) begin
            r_d.rescan = 1'b0;
        end
        case (r_q.st)
            ST_IDLE: begin
                if (r_q.rescan && !r_q.mv && cfg_enable) begin
                    r_d.st     = ST_SCAN;
                    r_d.idx    = '0;
                    r_d.rescan = 1'b0;
                    r_d.pend   = r_q.pend & live_bits;
                end else if (acc && cfg_enable) begin
                    if (!cur_in_range) begin
                        r_d.err = 1'b1;
                    end else if (cur_masked) begin
                        r_d.pend[cur_vec] = 1'b1;
                    end else begin
                        r_d.mv    = 1'b1;
                        r_d.maddr = fmt_addr;
                        r_d.mdata = fmt_data;
                    end
                end
            end
            ST_SCAN: begin
                if (!cfg_enable) begin
                    r_d.st = ST_IDLE;
                end else if (!r_q.mv) begin
                    if (r_q.pend[r_q.idx] && !cur_masked) begin
                        r_d.pend[r_q.idx] = 1'b0;
                        r_d.mv    = 1'b1;
                        r_d.maddr = fmt_addr;
                        r_d.mdata = fmt_data;
                    end
                    if (cur_last) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (cfg_wr && cfg_enable) begin
            r_d.rescan = 1'b1;
        end
        if (!cfg_mask_cap) begin
            r_d.pend = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, idx: '0, rescan: 1'b0, pend: '0, err: 1'b0,
                     mv: 1'b0, maddr: '0, mdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign msg_valid = r_q.mv;
    assign msg_addr  = r_q.maddr;
    assign msg_data  = r_q.mdata;
    assign pend      = r_q.pend;
    assign err       = r_q.err;

    // R1: masked request becomes pending and sends nothing
    a_r1_masked_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cfg_enable && cur_in_range && cur_masked)
            |=> (!msg_valid && pend[$past(req_vec)]));

    // R2: without masking the pending bits stay clear
    a_r2_no_pend_without_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mask_cap |=> (pend == '0));

    // R4: upper data half is always zero on an offered message
    a_r4_data_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_data[31:16] == 16'h0));

    // R5: error flag is sticky
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R8: requests held off while a rescan is pending or running
    a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SCAN || r_q.rescan) |-> !req_ready);

    // R9: disabled requests never produce a message
    a_r9_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !cfg_enable) |=> !msg_valid);

    // R10: a stalled message holds its contents
    a_r10_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready)
            |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
endmodule

// File: tb/msi_vec_engine_tb.sv
`timescale 1ns/1ps
module msi_vec_engine_tb;
    localparam int MAX_VEC = 8;
    localparam int VEC_W   = $clog2(MAX_VEC);
    localparam int LOG_W   = $clog2($clog2(MAX_VEC) + 1);
    localparam int LOG_MAX = $clog2(MAX_VEC);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_enable = 1'b0;
    logic               cfg_addr64 = 1'b0;
    logic               cfg_mask_cap = 1'b0;
    logic [LOG_W-1:0]   cfg_log_n = '0;
    logic [31:0]        cfg_addr_lo = '0;
    logic [31:0]        cfg_addr_hi = '0;
    logic [15:0]        cfg_data = '0;
    logic [MAX_VEC-1:0] cfg_mask = '0;
    logic               cfg_wr = 1'b0;
    logic               req_valid = 1'b0;
    logic [VEC_W-1:0]   req_vec = '0;
    logic               req_ready;
    logic               msg_valid;
    logic               msg_ready = 1'b1;
    logic [63:0]        msg_addr;
    logic [31:0]        msg_data;
    logic [MAX_VEC-1:0] pend;
    logic               err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] q_addr[$];
    logic [31:0] q_data[$];
    logic [MAX_VEC-1:0] m_pend;
    logic               m_err;

    always #2 clk = ~clk;

    msi_vec_engine #(.MAX_VEC(MAX_VEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_addr64(cfg_addr64),
        .cfg_mask_cap(cfg_mask_cap), .cfg_log_n(cfg_log_n), .cfg_addr_lo(cfg_addr_lo),
        .cfg_addr_hi(cfg_addr_hi), .cfg_data(cfg_data), .cfg_mask(cfg_mask),
        .cfg_wr(cfg_wr), .req_valid(req_valid), .req_vec(req_vec),
        .req_ready(req_ready), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data), .pend(pend), .err(err)
    );

    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            q_addr.push_back(msg_addr);
            q_data.push_back(msg_data);
        end
    end

    function automatic logic [63:0] exp_addr(input logic a64, input logic [31:0] lo,
                                             input logic [31:0] hi);
        return a64 ? {hi, lo} : {32'h0, lo};
    endfunction

    function automatic logic [31:0] exp_data(input logic [15:0] d,
                                             input logic [LOG_W-1:0] lg, input int v);
        logic [31:0] lowm;
        lowm = (32'd1 << lg) - 32'd1;
        return ({16'h0, d} & ~lowm) | 32'(v);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic expect_msg(input string req, input logic [63:0] ea, input logic [31:0] ed);
        if (q_addr.size() == 0) begin
            check(1'b0, req, "missing message", 64'h0, ea);
        end else begin
            logic [63:0] a;
            logic [31:0] d;
            a = q_addr.pop_front();
            d = q_data.pop_front();
            check(a == ea, req, "msg_addr", a, ea);
            check(d == ed, req, "msg_data", 64'(d), 64'(ed));
        end
    endtask

    task automatic expect_none(input string req);
        check(q_addr.size() == 0, req, "message count", 64'(q_addr.size()), 64'h0);
        q_addr.delete();
        q_data.delete();
    endtask

    task automatic send_req(input int v);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vec   = VEC_W'(v);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_wr();
        @(negedge clk);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (2 * MAX_VEC + 8) @(negedge clk);
    endtask

    task automatic model_rescan(output int list[$]);
        list.delete();
        if (!cfg_enable) return;
        for (int v = 0; v < MAX_VEC; v++) begin
            if (v >= (1 << cfg_log_n)) m_pend[v] = 1'b0;
        end
        for (int v = 0; v < (1 << cfg_log_n); v++) begin
            if (m_pend[v] && !(cfg_mask_cap && cfg_mask[v])) begin
                m_pend[v] = 1'b0;
                list.push_back(v);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int exp_list[$];
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(msg_valid == 1'b0, "R11", "msg_valid", 64'(msg_valid), 64'h0);
        check(err == 1'b0, "R11", "err", 64'(err), 64'h0);
        check(pend == '0, "R11", "pend", 64'(pend), 64'h0);
        check(req_ready == 1'b1, "R11", "req_ready", 64'(req_ready), 64'h1);

        // R3/R4: 32-bit addressing, N=8, vector merged into data
        cfg_enable = 1; cfg_mask_cap = 1; cfg_mask = '0; cfg_log_n = 2'd3;
        cfg_addr64 = 0; cfg_addr_lo = 32'hFEE0_1000; cfg_addr_hi = 32'h1234_5678;
        cfg_data = 16'h1230;
        send_req(5);
        expect_msg("R3", 64'h0000_0000_FEE0_1000, 32'h0000_1235);
        // R3: 64-bit addressing
        cfg_addr64 = 1;
        send_req(7);
        expect_msg("R3", 64'h1234_5678_FEE0_1000, 32'h0000_1237);
        // R4: single vector leaves template intact
        cfg_log_n = 2'd0; cfg_data = 16'hBEEF;
        send_req(0);
        expect_msg("R4", 64'h1234_5678_FEE0_1000, 32'h0000_BEEF);
        expect_none("R4");

        // R5: out-of-range request, then sticky flag
        cfg_log_n = 2'd1; cfg_data = 16'h1230;
        send_req(3);
        expect_none("R5");
        check(err == 1'b1, "R5", "err", 64'(err), 64'h1);
        send_req(1);
        expect_msg("R5", 64'h1234_5678_FEE0_1000, 32'h0000_1231);
        check(err == 1'b1, "R5", "err sticky", 64'(err), 64'h1);

        // R1: masked requests pend with no message
        cfg_log_n = 2'd3; cfg_mask = 8'hFF;
        send_req(1); send_req(2); send_req(3); send_req(6);
        expect_none("R1");
        check(pend == 8'h4E, "R1", "pend", 64'(pend), 64'h4E);

        // R6/R7/R8: shrink to N=4, unmask 1 and 2, rescan
        cfg_log_n = 2'd2; cfg_mask = 8'hF9;
        @(negedge clk);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        check(req_ready == 1'b0, "R8", "req_ready during rescan", 64'(req_ready), 64'h0);
        repeat (2 * MAX_VEC + 8) @(negedge clk);
        expect_msg("R7", 64'h1234_5678_FEE0_1000, 32'h0000_1231);
        expect_msg("R7", 64'h1234_5678_FEE0_1000, 32'h0000_1232);
        expect_none("R7");
        check(pend == 8'h08, "R6", "pend after trim and replay", 64'(pend), 64'h08);
        check(req_ready == 1'b1, "R8", "req_ready after rescan", 64'(req_ready), 64'h1);

        // R9: disabled engine discards requests and ignores writes
        cfg_enable = 0; cfg_mask = 8'h00;
        send_req(0);
        pulse_wr();
        expect_none("R9");
        check(pend == 8'h08, "R9", "pend unchanged", 64'(pend), 64'h08);

        // R10: back-pressure holds the message
        cfg_enable = 1; cfg_addr64 = 0; msg_ready = 0;
        send_req(0);
        repeat (3) @(negedge clk);
        check(msg_valid == 1'b1, "R10", "msg_valid held", 64'(msg_valid), 64'h1);
        check(msg_data == 32'h0000_1230, "R10", "held data", 64'(msg_data), 64'h1230);
        msg_ready = 1;
        repeat (2) @(negedge clk);
        expect_msg("R10", 64'h0000_0000_FEE0_1000, 32'h0000_1230);
        expect_none("R10");

        // R2: no masking capability means nothing is masked
        cfg_mask_cap = 0; cfg_mask = 8'hFF; cfg_log_n = 2'd3;
        send_req(3);
        expect_msg("R2", 64'h0000_0000_FEE0_1000, 32'h0000_1233);
        check(pend == '0, "R2", "pend", 64'(pend), 64'h0);

        // Random phase, all requirements against the bench model
        m_pend = pend;
        m_err  = err;
        for (int it = 0; it < 300; it++) begin
            int v;
            bit ok;
            @(negedge clk);
            cfg_enable   = ($urandom % 8) != 0;
            cfg_mask_cap = $urandom % 4 != 0;
            cfg_log_n    = LOG_W'($urandom % (LOG_MAX + 1));
            cfg_mask     = MAX_VEC'($urandom);
            cfg_addr64   = $urandom % 2;
            cfg_addr_lo  = $urandom;
            cfg_addr_hi  = $urandom;
            cfg_data     = 16'($urandom);
            if (!cfg_mask_cap) m_pend = '0;
            exp_list.delete();
            if ($urandom % 10 < 7) begin
                v = $urandom % MAX_VEC;
                if (cfg_enable) begin
                    if (v >= (1 << cfg_log_n)) m_err = 1'b1;
                    else if (cfg_mask_cap && cfg_mask[v]) m_pend[v] = 1'b1;
                    else exp_list.push_back(v);
                end
                send_req(v);
            end else begin
                model_rescan(exp_list);
                pulse_wr();
            end
            ok = (q_addr.size() == exp_list.size());
            for (int k = 0; k < exp_list.size() && ok; k++) begin
                if (q_addr[k] != exp_addr(cfg_addr64, cfg_addr_lo, cfg_addr_hi) ||
                    q_data[k] != exp_data(cfg_data, cfg_log_n, exp_list[k])) ok = 0;
            end
            check(ok, "R7", "random message stream", 64'(q_addr.size()), 64'(exp_list.size()));
            check(pend == m_pend && err == m_err, "R1", "random pend/err",
                  {55'h0, err, pend}, {55'h0, m_err, m_pend});
            q_addr.delete();
            q_data.delete();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule